// File: doc/BRIEF.md
# Staggered Channel Enable Sequencer

This block sits between five regulator channel enable requests and the channel power stages. It turns each request into a gated run signal, so the channels start in a fixed order and the input inrush stays low. Each channel waits its own fixed delay. Channel 1 waits a short fixed time. Channels 2 to 5 wait one, two, three and four times a base interval. Each delay is counted from the moment that channel's request is high and no global fault is present. A global fault covers input undervoltage lockout, input overvoltage lockout and thermal shutdown.

A global fault removes every run signal in the same cycle and clears every timer. When the fault goes away, the whole staggered start replays from the beginning. An output overvoltage on one channel only pauses that channel, and the channel resumes as soon as the overvoltage clears. The block also drives two per-channel outputs:
- a soft-start-busy flag, which covers the soft-start time after each start of run;
- a discharge-switch control, which follows the inverse of the channel's request.

All times are counted in clock cycles and set through parameters. The defaults assume a 50 MHz clock.

Top module: `staggered_enable_seq`

## Requirements
- R1: While reset is asserted and right after it is released, every run and soft-start-busy output is low. Bit i of each vector belongs to channel i+1.
- R2: Consider a channel whose request is held high with no global fault. Its run output goes high after exactly the number of rising clock edges given by its delay: FIRST_DLY for channel 1, and (k-1)*BASE_DLY for channel k when k is 2 to 5. With all requests raised together, the channels therefore start in the order 1, 2, 3, 4, 5.
- R3: Each channel times only from its own request. When the requests arrive at different times, each run output rises its own delay after its own request.
- R4: If a request drops before its delay has elapsed, that channel's timer is cancelled and run stays low. A later request starts the full delay again.
- R5: While the global fault input is high, all run outputs and all busy outputs are low in that same cycle. When the fault clears, each enabled channel again waits its full delay from that point.
- R6: While a channel's overvoltage input is high, that channel's run output is low in the same cycle and the other channels are not affected. Once a channel's delay has elapsed, run returns in the cycle its overvoltage input clears.
- R7: Soft-start-busy goes high in the cycle run rises. It stays high for SS_MAIN clock edges on channels 1 to 4 and for SS_LAST edges on channel 5, then goes low while run stays high.
- R8: Soft-start-busy is never high without run. If run drops during soft start, busy drops in the same cycle, and the next rise of run starts a fresh soft-start period.
- R9: A channel's discharge control is high in the same cycle that the channel's request is low, and low while the request is high. A channel never has run and discharge high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | NCH | Per-channel enable requests |
| fault_i | input | 1 | Global fault: input lockout, input overvoltage or thermal shutdown |
| ov_i | input | NCH | Per-channel output overvoltage flags |
| run_o | output | NCH | Gated channel run signals |
| busy_o | output | NCH | Per-channel soft-start-busy flags |
| dis_o | output | NCH | Per-channel discharge-switch controls |

## Verification
The hardest situations to reach from the ports are those where an event lands partway through the staggered start:
- a global fault arriving while later channels are still waiting;
- a request dropping just before its timer completes;
- an overvoltage cutting into a soft-start period.

The bench shrinks the delays to a few cycles, so the longest wait is 32 edges. Directed phases place faults, dropped requests and overvoltages at known points of the sequence. A long stretch of sparse random toggles then lands these events at every stage, and a cycle-by-cycle arithmetic expectation is compared on every output.

// File: rtl/staggered_enable_seq.sv
module staggered_enable_seq #(
  parameter int unsigned NCH       = 5,
  parameter int unsigned FIRST_DLY = 750,
  parameter int unsigned BASE_DLY  = 30000,
  parameter int unsigned SS_MAIN   = 25000,
  parameter int unsigned SS_LAST   = 28500
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] en_i,
  input  logic           fault_i,
  input  logic [NCH-1:0] ov_i,
  output logic [NCH-1:0] run_o,
  output logic [NCH-1:0] busy_o,
  output logic [NCH-1:0] dis_o
);

  function automatic int unsigned dly_of(int unsigned idx);
    return (idx == 0) ? FIRST_DLY : idx * BASE_DLY;
  endfunction

  localparam int unsigned LAST_DLY = (NCH - 1) * BASE_DLY;
  localparam int unsigned MAX_DLY  = (LAST_DLY > FIRST_DLY) ? LAST_DLY : FIRST_DLY;
  localparam int unsigned MAX_SS   = (SS_LAST > SS_MAIN) ? SS_LAST : SS_MAIN;
  localparam int unsigned DW       = $clog2(MAX_DLY + 1);
  localparam int unsigned SW       = $clog2(MAX_SS + 1);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam logic [DW-1:0] DLY = DW'(dly_of(g));
    localparam logic [SW-1:0] SST = SW'((g == NCH - 1) ? SS_LAST : SS_MAIN);

    logic [DW-1:0] dcnt;
    logic [SW-1:0] scnt;
    logic          armed;
    logic          run;

    assign armed = en_i[g] & ~fault_i;
    assign run   = armed & (dcnt == DLY) & ~ov_i[g];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        dcnt <= '0;
        scnt <= '0;
      end else begin
        if (!armed)           dcnt <= '0;
        else if (dcnt != DLY) dcnt <= dcnt + 1'b1;
        if (!run)             scnt <= '0;
        else if (scnt != SST) scnt <= scnt + 1'b1;
      end
    end

    assign run_o[g]  = run;
    assign busy_o[g] = run & (scnt != SST);
    assign dis_o[g]  = ~en_i[g];
  end

endmodule

// File: rtl/staggered_enable_seq_chk.sv
module staggered_enable_seq_chk #(
  parameter int unsigned NCH = 5
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [NCH-1:0] en_i,
  input logic           fault_i,
  input logic [NCH-1:0] ov_i,
  input logic [NCH-1:0] run_o,
  input logic [NCH-1:0] busy_o,
  input logic [NCH-1:0] dis_o
);

  assert_fault_stops_all_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_i |-> (run_o == '0 && busy_o == '0));

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    assert_ov_stops_channel_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ov_i[g] |-> !run_o[g]);
    assert_no_run_with_discharge_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(run_o[g] && dis_o[g]));
    assert_busy_needs_run_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_o[g] |-> run_o[g]);
    assert_busy_at_start_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(run_o[g]) |-> busy_o[g]);
    assert_armed_before_run_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(run_o[g]) |-> $past(en_i[g] && !fault_i));
  end

endmodule

bind staggered_enable_seq staggered_enable_seq_chk #(.NCH(NCH)) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .en_i    (en_i),
  .fault_i (fault_i),
  .ov_i    (ov_i),
  .run_o   (run_o),
  .busy_o  (busy_o),
  .dis_o   (dis_o)
);

// File: tb/staggered_enable_seq_tb_top.sv
module staggered_enable_seq_tb_top;
  localparam int NCH = 5;
  localparam int FD  = 3;
  localparam int BD  = 8;
  localparam int SM  = 5;
  localparam int SL  = 7;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH-1:0] en = '0;
  logic [NCH-1:0] ov = '0;
  logic           fault = 1'b0;
  logic [NCH-1:0] run, busy, dis;

  always #10 clk = ~clk;

  staggered_enable_seq #(
    .NCH(NCH), .FIRST_DLY(FD), .BASE_DLY(BD), .SS_MAIN(SM), .SS_LAST(SL)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .fault_i(fault), .ov_i(ov),
    .run_o(run), .busy_o(busy), .dis_o(dis)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int a_cnt[NCH];
  int s_cnt[NCH];

  function automatic int dly(int i);
    return (i == 0) ? FD : i * BD;
  endfunction

  function automatic int sst(int i);
    return (i == NCH - 1) ? SL : SM;
  endfunction

  task automatic check(string req, string what, logic [NCH-1:0] got, logic [NCH-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, got, exp);
    end
  endtask

  task automatic check_int(string req, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, got, exp);
    end
  endtask

  task automatic step(string req);
    logic [NCH-1:0] er, eb;
    @(posedge clk);
    for (int i = 0; i < NCH; i++) begin
      bit armed, rp;
      if (!rst_n) begin
        a_cnt[i] = 0;
        s_cnt[i] = 0;
      end else begin
        armed = en[i] && !fault;
        rp = armed && (a_cnt[i] == dly(i)) && !ov[i];
        s_cnt[i] = rp ? ((s_cnt[i] < sst(i)) ? s_cnt[i] + 1 : s_cnt[i]) : 0;
        a_cnt[i] = !armed ? 0 : ((a_cnt[i] < dly(i)) ? a_cnt[i] + 1 : a_cnt[i]);
      end
    end
    @(negedge clk);
    for (int i = 0; i < NCH; i++) begin
      er[i] = en[i] && !fault && (a_cnt[i] == dly(i)) && !ov[i];
      eb[i] = er[i] && (s_cnt[i] < sst(i));
    end
    check(req, "run", run, er);
    check(req, "busy", busy, eb);
    check(req, "discharge", dis, ~en);
  endtask

  task automatic rise_times(string req, int n, logic [NCH-1:0] mask);
    int first[NCH];
    for (int i = 0; i < NCH; i++) first[i] = -1;
    for (int c = 1; c <= n; c++) begin
      step(req);
      for (int i = 0; i < NCH; i++)
        if (run[i] && first[i] < 0) first[i] = c;
    end
    for (int i = 0; i < NCH; i++)
      if (mask[i]) check_int(req, $sformatf("start edge ch%0d", i + 1), first[i], dly(i));
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NCH; i++) begin a_cnt[i] = 0; s_cnt[i] = 0; end
    repeat (3) step("R1");
    check("R1", "run in reset", run, '0);
    check("R1", "busy in reset", busy, '0);
    rst_n = 1'b1;
    repeat (3) step("R1");

    en = '1;
    rise_times("R2", 45, '1);

    fault = 1'b1;
    step("R5");
    check("R5", "run during fault", run, '0);
    check("R5", "busy during fault", busy, '0);
    step("R5");
    fault = 1'b0;
    rise_times("R5", 45, '1);
    fault = 1'b1; step("R5");
    fault = 1'b0; repeat (12) step("R5");
    fault = 1'b1; step("R5");
    fault = 1'b0;
    rise_times("R5", 45, '1);

    ov = 5'b00010;
    repeat (4) step("R6");
    check("R6", "other channels keep running", run, 5'b11101);
    ov = '0;
    step("R6");
    check("R6", "run back after ov clears", run, '1);
    step("R8");
    ov = 5'b00010;
    step("R8");
    check("R8", "busy drops with run", busy & 5'b00010, '0);
    ov = '0;
    repeat (10) step("R7");

    en = '0;
    repeat (3) step("R9");
    check("R9", "discharge with enables low", dis, '1);
    en = 5'b00100;
    repeat (BD * 2 - 1) step("R4");
    en = '0;
    repeat (3) step("R4");
    check("R4", "cancelled channel idle", run, '0);
    en = 5'b00100;
    rise_times("R4", 25, 5'b00100);

    en = '0;
    repeat (3) step("R3");
    for (int k = NCH - 1; k >= 0; k--) begin
      en[k] = 1'b1;
      repeat (5) step("R3");
    end
    repeat (40) step("R3");

    for (int c = 0; c < 6000; c++) begin
      if ($urandom_range(0, 39) == 0) en[$urandom_range(0, NCH - 1)] ^= 1'b1;
      if ($urandom_range(0, 149) == 0) fault = ~fault;
      if ($urandom_range(0, 59) == 0) ov[$urandom_range(0, NCH - 1)] ^= 1'b1;
      step("R7");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule